// File: doc/BRIEF.md
# Two-Table Vector Permute Unit

This unit rebuilds a vector register of up to 512 bits by gathering elements from two tables. The first table is the current destination contents and the second table is a separate input vector. A per-lane index vector chooses, for every destination lane, which table to read and which element inside it. Elements may be 16, 32 or 64 bits wide, and the active vector length may be 128, 256 or 512 bits. The position of the table-select bit inside each index depends on both of these settings.

A per-lane writemask, when enabled, either keeps the old destination value of an unselected lane (merging) or clears it (zeroing). For 32-bit and 64-bit elements, a broadcast mode replaces every second-table read with the lowest element of the second-table input. Every lane reads the first table from the destination value presented with the request, so one lane's write can never feed another lane in the same operation. The result is registered when a request strobe is high, and a valid flag is raised in the following cycle.

Top module: `perm2_unit`

## Requirements
- R1: Element size code `sizeCode` is 0=16, 1=32, 2=64 bits, and vector length code `lenCode` is 0=128, 1=256, 2=512 bits. For 64-bit elements, lane j reads index element j; index bit 1, 2 or 3 (at 128/256/512) selects the table, and the bits below it pick the element.
- R2: For 32-bit elements the table-select bit is index bit 2, 3 or 4, and for 16-bit elements it is bit 3, 4 or 5 (at 128/256/512). The bits below it pick the element.
- R3: A select bit of 0 reads the destination value presented with the request, never a value written by another lane of the same operation. Index bits above the select bit are ignored, and one source element may fill several lanes.
- R4: When `maskEn` is 1 and mask bit j (`laneMask[j]` for lane j) is 0, lane j keeps its old destination value if `zeroMode` is 0 and becomes zero if `zeroMode` is 1. When `maskEn` is 0, every lane is written whatever the mask holds.
- R5: With `bcastEn` set and 32-bit or 64-bit elements, a lane whose select bit is 1 receives element 0 of `tabIn`. Lanes that select the first table are unaffected.
- R6: With `bcastEn` set and 16-bit elements, broadcast is ignored and the result equals the non-broadcast result.
- R7: Result bits at and above the active vector length are zero.
- R8: A `lenCode` or `sizeCode` of 3 produces an all-zero result.
- R9: A request with `reqValid` high updates `resOut` at that clock edge, and `resValid` is high in the next cycle only. Without a request, `resOut` holds its value.
- R10: A synchronous active-low reset clears `resOut` and `resValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request strobe; captures a new result |
| destIn | input | 512 | Old destination contents, also the first table |
| idxIn | input | 512 | Per-lane index vector |
| tabIn | input | 512 | Second table |
| laneMask | input | 32 | Writemask, bit j for lane j |
| sizeCode | input | 2 | Element size code |
| lenCode | input | 2 | Vector length code |
| zeroMode | input | 1 | 1 = zero masked lanes, 0 = merge |
| maskEn | input | 1 | 1 = apply the writemask |
| bcastEn | input | 1 | 1 = broadcast element 0 of the second table |
| resOut | output | 512 | Registered result |
| resValid | output | 1 | High the cycle after a request |

## Verification
A wrong select-bit position or element decode shows up as one or more wrong lanes in the very next `resOut` after the request, so each request is compared lane-for-lane one cycle after it is issued against a model derived from the requirements. A stale or corrupted first-table snapshot shows up only on lanes that select table one with mixed indices, so random indices, including random upper bits, are applied under every size and length. A faulty hold or valid path shows at the ports in the idle cycles between requests, where `resOut` is compared with the last result on every cycle.

// File: rtl/perm2_pkg.sv
package perm2_pkg;
  localparam int MAX_VL    = 512;
  localparam int MIN_EW    = 16;
  localparam int NUM_SIZES = 3;
  localparam int MASK_W    = MAX_VL / MIN_EW;
  // log2 of the lane count for the narrowest element at the shortest length
  localparam int LG_BASE   = 3;

  localparam logic [1:0] SIZE16 = 2'd0;

  typedef struct packed {
    logic       load;
    logic       legal;
    logic [1:0] sizeSel;
    logic [1:0] lenSel;
    logic       bcastOn;
    logic       maskOn;
    logic       zeroOn;
  } perm2_ctl_t;
endpackage

// File: rtl/perm2_ctrl.sv
module perm2_ctrl
  import perm2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [1:0] sizeCode,
  input  logic [1:0] lenCode,
  input  logic       zeroMode,
  input  logic       maskEn,
  input  logic       bcastEn,
  output perm2_ctl_t ctl,
  output logic       resValid
);
  always_comb begin
    ctl.load    = reqValid;
    ctl.legal   = (sizeCode != 2'd3) && (lenCode != 2'd3);
    ctl.sizeSel = sizeCode;
    ctl.lenSel  = lenCode;
    // R6: no broadcast for the narrowest element
    ctl.bcastOn = bcastEn && (sizeCode != SIZE16);
    ctl.maskOn  = maskEn;
    ctl.zeroOn  = zeroMode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resValid <= 1'b0;
    else        resValid <= reqValid;
  end

  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> resValid);
  // R9
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !resValid);
endmodule

// File: rtl/perm2_dp.sv
module perm2_dp
  import perm2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  perm2_ctl_t        ctl,
  input  logic [MAX_VL-1:0] destIn,
  input  logic [MAX_VL-1:0] idxIn,
  input  logic [MAX_VL-1:0] tabIn,
  input  logic [MASK_W-1:0] laneMask,
  output logic [MAX_VL-1:0] resOut
);
  logic [MAX_VL-1:0] cand [NUM_SIZES];
  logic [MAX_VL-1:0] nextRes;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int EW    = MIN_EW << s;
    localparam int LANES = MAX_VL / EW;
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [EW-1:0] ix;
      logic [EW-1:0] picked;
      logic [EW-1:0] laneVal;
      logic [5:0]    elem;
      logic [5:0]    lowMask;
      int unsigned   lg;
      logic          pickTab;
      always_comb begin
        // R1 R2: select bit sits just above the in-table element bits
        lg      = unsigned'(LG_BASE - s) + {30'd0, ctl.lenSel};
        lowMask = (6'd1 << lg) - 6'd1;
        ix      = idxIn[j*EW +: EW];
        elem    = ix[5:0] & lowMask;       // R3: upper index bits dropped
        pickTab = ix[lg];
        if (pickTab)
          picked = ctl.bcastOn ? tabIn[EW-1:0] : tabIn[elem*EW +: EW];  // R5
        else
          picked = destIn[elem*EW +: EW];  // R3: original destination only
        if (j >= (1 << lg))
          laneVal = '0;                    // R7
        else if (ctl.maskOn && !laneMask[j])
          laneVal = ctl.zeroOn ? '0 : destIn[j*EW +: EW];  // R4
        else
          laneVal = picked;
      end
      assign cand[s][j*EW +: EW] = laneVal;
    end
  end

  always_comb begin
    if (!ctl.legal) nextRes = '0;          // R8
    else            nextRes = cand[ctl.sizeSel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        resOut <= '0;
    else if (ctl.load) resOut <= nextRes;
  end

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.load |=> $stable(resOut));
  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load && !ctl.legal) |=> (resOut == '0));
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load && ctl.lenSel == 2'd0) |=> (resOut[MAX_VL-1:128] == '0));
  // R4
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load && ctl.legal && ctl.maskOn && !ctl.zeroOn && !laneMask[0])
      |=> (resOut[MIN_EW-1:0] == $past(destIn[MIN_EW-1:0])));
  // R4
  zero_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.load && ctl.legal && ctl.maskOn && ctl.zeroOn && !laneMask[0])
      |=> (resOut[MIN_EW-1:0] == '0));
endmodule

// File: rtl/perm2_unit.sv
module perm2_unit
  import perm2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [MAX_VL-1:0] destIn,
  input  logic [MAX_VL-1:0] idxIn,
  input  logic [MAX_VL-1:0] tabIn,
  input  logic [MASK_W-1:0] laneMask,
  input  logic [1:0]        sizeCode,
  input  logic [1:0]        lenCode,
  input  logic              zeroMode,
  input  logic              maskEn,
  input  logic              bcastEn,
  output logic [MAX_VL-1:0] resOut,
  output logic              resValid
);
  perm2_ctl_t ctl;

  perm2_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .sizeCode(sizeCode), .lenCode(lenCode), .zeroMode(zeroMode),
    .maskEn(maskEn), .bcastEn(bcastEn), .ctl(ctl), .resValid(resValid)
  );

  perm2_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .destIn(destIn), .idxIn(idxIn),
    .tabIn(tabIn), .laneMask(laneMask), .resOut(resOut)
  );
endmodule

// File: tb/test_perm2_unit.sv
module test_perm2_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reqValid = 1'b0;
  logic [511:0] destIn = '0, idxIn = '0, tabIn = '0;
  logic [31:0]  laneMask = '0;
  logic [1:0]   sizeCode = '0, lenCode = '0;
  logic         zeroMode = 1'b0, maskEn = 1'b0, bcastEn = 1'b0;
  logic [511:0] resOut;
  logic         resValid;

  int checks = 0;
  int errors = 0;
  logic [511:0] expQ [$];
  string        tagQ [$];
  logic [511:0] lastRes = '0;

  always #4 clk = ~clk;  // 125 MHz

  perm2_unit i_perm2_unit (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .destIn(destIn),
    .idxIn(idxIn), .tabIn(tabIn), .laneMask(laneMask), .sizeCode(sizeCode),
    .lenCode(lenCode), .zeroMode(zeroMode), .maskEn(maskEn), .bcastEn(bcastEn),
    .resOut(resOut), .resValid(resValid)
  );

  function automatic logic [511:0] model(
    logic [511:0] d, logic [511:0] ix, logic [511:0] t, logic [31:0] m,
    int es, int vl, bit zm, bit me, bit bc);
    logic [511:0] r = '0;
    logic [511:0] wm, sh, v;
    int w, n, tb, e;
    if (es == 3 || vl == 3) return '0;
    w  = 16 << es;
    n  = (128 << vl) / w;
    tb = 0;
    while ((1 << tb) < n) tb++;
    wm = ({512{1'b1}} >> (512 - w));
    for (int j = 0; j < n; j++) begin
      sh = ix >> (j * w);
      e  = int'(sh[5:0]) % n;
      if (sh[tb]) v = (bc && es != 0) ? (t & wm) : ((t >> (e * w)) & wm);
      else        v = (d >> (e * w)) & wm;
      if (me && !m[j]) v = zm ? '0 : ((d >> (j * w)) & wm);
      r = r | (v << (j * w));
    end
    return r;
  endfunction

  function automatic logic [511:0] pat(int seed);
    logic [511:0] p;
    for (int k = 0; k < 16; k++)
      p[k*32 +: 32] = (32'(seed) * 32'h9E3779B1) ^ (32'(k) * 32'h01030507) ^ 32'h5A5A0000;
    return p;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] p;
    for (int k = 0; k < 16; k++) p[k*32 +: 32] = $urandom;
    return p;
  endfunction

  task automatic send(string tag, logic [511:0] d, logic [511:0] ix,
                      logic [511:0] t, logic [31:0] m, int es, int vl,
                      bit zm, bit me, bit bc);
    @(negedge clk);
    destIn = d; idxIn = ix; tabIn = t; laneMask = m;
    sizeCode = 2'(es); lenCode = 2'(vl);
    zeroMode = zm; maskEn = me; bcastEn = bc; reqValid = 1'b1;
    expQ.push_back(model(d, ix, t, m, es, vl, zm, me, bc));
    tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      idxIn = rnd512();  // changing idle inputs must not matter (R9)
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) lastRes = '0;
    else if (resValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected valid, got %h expected none", resOut);
      end else begin
        logic [511:0] ex;
        string tg;
        ex = expQ.pop_front();
        tg = tagQ.pop_front();
        if (resOut !== ex) begin
          errors++;
          $display("FAIL %s: got %h expected %h", tg, resOut, ex);
        end
        lastRes = resOut;
      end
    end else begin
      checks++;
      if (resOut !== lastRes) begin
        errors++;
        $display("FAIL R9 hold: got %h expected %h", resOut, lastRes);
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] dupIdx, revIdx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (resOut !== '0 || resValid !== 1'b0) begin
      errors++;
      $display("FAIL R10: got %h/%b expected 0/0", resOut, resValid);
    end

    // R1: 64-bit, each length, reversal mixing tables
    revIdx = '0;
    for (int j = 0; j < 8; j++) revIdx[j*64 +: 64] = 64'(15 - 2 * (j % 8));
    send("R1 q512 rev", pat(1), revIdx, pat(2), '1, 2, 2, 0, 0, 0);
    send("R1 q256", pat(3), rnd512(), pat(4), '1, 2, 1, 0, 0, 0);
    send("R1 q128", pat(5), rnd512(), pat(6), '1, 2, 0, 0, 0, 0);
    idle(2);
    // R2: 32-bit and 16-bit at every length
    for (int vl = 0; vl < 3; vl++) begin
      send("R2 d", pat(10 + vl), rnd512(), pat(20 + vl), '1, 1, vl, 0, 0, 0);
      send("R2 w", pat(30 + vl), rnd512(), pat(40 + vl), '1, 0, vl, 0, 0, 0);
    end
    idle(2);
    // R3: every lane picks first-table element 0, high index bits set
    dupIdx = '0;
    for (int j = 0; j < 16; j++) dupIdx[j*32 +: 32] = 32'hFFFF_FF00 | 32'h0;
    send("R3 dup", pat(50), dupIdx, pat(51), '1, 1, 2, 0, 0, 0);
    for (int k = 0; k < 6; k++)
      send("R3 rnd", rnd512(), rnd512(), rnd512(), '1, k % 3, 2, 0, 0, 0);
    idle(3);
    // R4: merging, zeroing, masking disabled
    send("R4 merge", pat(60), rnd512(), pat(61), 32'hA5C3_0F96, 1, 2, 0, 1, 0);
    send("R4 zero", pat(62), rnd512(), pat(63), 32'h5A3C_F069, 0, 2, 1, 1, 0);
    send("R4 nomask", pat(64), rnd512(), pat(65), 32'h0, 2, 2, 1, 0, 0);
    idle(2);
    // R5: broadcast at 32 and 64 bits
    send("R5 bq", pat(70), rnd512(), pat(71), '1, 2, 2, 0, 0, 1);
    send("R5 bd", pat(72), rnd512(), pat(73), 32'h0F0F_F0F0, 1, 1, 0, 1, 1);
    // R6: broadcast ignored at 16 bits
    send("R6 bw", pat(74), rnd512(), pat(75), '1, 0, 2, 0, 0, 1);
    idle(2);
    // R7: short lengths clear upper bits
    send("R7 w128", pat(80), rnd512(), pat(81), '1, 0, 0, 0, 0, 0);
    send("R7 d256", pat(82), rnd512(), pat(83), 32'h0000_00F0, 1, 1, 0, 1, 0);
    idle(1);
    // R8: unsupported codes
    send("R8 len3", pat(90), rnd512(), pat(91), '1, 1, 3, 0, 0, 0);
    idle(2);
    send("R8 size3", pat(92), rnd512(), pat(93), '1, 3, 2, 0, 0, 0);
    idle(4);
    // R10: reset in mid-run after a nonzero result
    send("R9 pre-reset", pat(95), rnd512(), pat(96), '1, 2, 2, 0, 0, 0);
    idle(2);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (resOut !== '0 || resValid !== 1'b0) begin
      errors++;
      $display("FAIL R10 mid: got %h/%b expected 0/0", resOut, resValid);
    end
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R9: got %0d pending results expected 0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule